// File: doc/BRIEF.md
# Quiz Buzzer Lockout Arbiter

This block referees a four-contestant quiz round. A single host button opens and closes the round, one press at a time. While the round is open, the first contestant whose button is pressed is recorded as the winner, and all other contestants are locked out. A contestant who presses while the round is closed is disqualified, and cannot win until the host closes the round again.

All five buttons are asynchronous to the block clock. They pass through a multi-stage synchronizer inside the block. The host button acts only on its rising edge. The block drives four indicator outputs: the open flag, a lock flag, a one-hot winner vector, and a seven-segment pattern that shows the winner's number. Debouncing is the job of the surrounding logic.

Top module: `quiz_lockout`

## Requirements
- R1: After synchronous active-high reset, `armed`, `locked`, `winner` and `seg` are all zero.
- R2: A button change is acted on at the (SYNC_STAGES+1)-th rising clock edge after it is applied. With the default of 2 stages, this is the third edge.
- R3: Each rising edge of the synchronized host button toggles `armed`. Holding the host button high causes no further toggles.
- R4: While armed with no winner, an eligible press of contestant i sets `winner` to a vector with only bit i set, and `locked` goes high.
- R5: Once a winner exists, later presses by any contestant leave `winner` unchanged until the round is closed.
- R6: A contestant whose synchronized button is high on any cycle while not armed is disqualified. That contestant cannot win in the round that follows, but the other contestants still can.
- R7: A button held down across the cycle in which the round opens counts as an early press, so the rule in R6 applies to it.
- R8: If several eligible contestants are first seen pressed in the same cycle, the lowest-numbered one wins.
- R9: Closing the round (armed to not armed) clears `winner`, `locked` and all disqualifications.
- R10: `seg` (bit 0 = segment a … bit 6 = segment g) takes the following values:
  - 7'b0000110 for winner 0001
  - 7'b1011011 for winner 0010
  - 7'b1001111 for winner 0100
  - 7'b1100110 for winner 1000
  - 0 otherwise
- R11: No winner is recorded while the round is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_btn | input | 1 | Host button, asynchronous level |
| player_btn | input | 4 | Contestant buttons, bit i = contestant i+1 |
| armed | output | 1 | Round is open |
| locked | output | 1 | A winner has been recorded |
| winner | output | 4 | One-hot winner vector |
| seg | output | 7 | Seven-segment pattern of the winner's number |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. With this setting the three-edge input latency in R2 can be pinned to an exact cycle. The bench applies each stimulus long enough to settle past the synchronizer and the edge detector. It then exercises the following:
- opening and closing rounds;
- single presses and simultaneous presses;
- presses made before the round opens;
- a button held down across the opening edge;
- all four segment patterns.

// File: rtl/qb_pkg.sv
package qb_pkg;
    localparam int N_PLAYERS = 4;
    localparam int SEG_W     = 7;

    typedef struct packed {
        logic                 armed;
        logic                 host_prev;
        logic [N_PLAYERS-1:0] winner;
        logic [N_PLAYERS-1:0] dq;
    } qb_state_t;
endpackage

// File: rtl/qb_sync.sv
module qb_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;
    logic [STAGES-1:0][WIDTH-1:0] chain_d;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/qb_pick.sv
module qb_pick #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] req,
    output logic [WIDTH-1:0] grant
);
    always_comb begin
        grant = '0;
        for (int i = WIDTH-1; i >= 0; i--) begin
            if (req[i]) grant = WIDTH'(1) << i;
        end
    end

    always_comb begin
        assert (grant == '0 || $onehot(grant))
            else $error("a_r8_pick_onehot");
        assert ((grant & ~req) == '0)
            else $error("a_r8_pick_subset");
    end
endmodule

// File: rtl/qb_digit.sv
module qb_digit
    import qb_pkg::*;
(
    input  logic [N_PLAYERS-1:0] code,
    output logic [SEG_W-1:0]     seg
);
    always_comb begin
        unique case (code)
            4'b0001: seg = 7'b0000110;
            4'b0010: seg = 7'b1011011;
            4'b0100: seg = 7'b1001111;
            4'b1000: seg = 7'b1100110;
            default: seg = '0;
        endcase
    end

    always_comb begin
        if (code == '0) assert (seg == '0) else $error("a_r10_blank_idle");
    end
endmodule

// File: rtl/quiz_lockout.sv
module quiz_lockout
    import qb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_btn,
    input  logic [N_PLAYERS-1:0] player_btn,
    output logic                 armed,
    output logic                 locked,
    output logic [N_PLAYERS-1:0] winner,
    output logic [SEG_W-1:0]     seg
);
    localparam int SYNC_W = N_PLAYERS + 1;

    logic [SYNC_W-1:0]    sync_v;
    logic                 host_s;
    logic [N_PLAYERS-1:0] ply_s;
    logic [N_PLAYERS-1:0] elig;
    logic [N_PLAYERS-1:0] grant;
    logic                 host_rise;
    qb_state_t            st_q, st_d;

    qb_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({host_btn, player_btn}),
        .sync_out (sync_v)
    );

    assign host_s = sync_v[SYNC_W-1];
    assign ply_s  = sync_v[N_PLAYERS-1:0];
    assign elig   = ply_s & ~st_q.dq;

    qb_pick #(.WIDTH(N_PLAYERS)) u_pick (
        .req   (elig),
        .grant (grant)
    );

    assign host_rise = host_s & ~st_q.host_prev;

    always_comb begin
        st_d           = st_q;
        st_d.host_prev = host_s;
        if (!st_q.armed) begin
            st_d.dq = st_q.dq | ply_s;
            if (host_rise) st_d.armed = 1'b1;
        end else if (host_rise) begin
            st_d.armed  = 1'b0;
            st_d.winner = '0;
            st_d.dq     = '0;
        end else if (st_q.winner == '0) begin
            st_d.winner = grant;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign armed  = st_q.armed;
    assign winner = st_q.winner;
    assign locked = |st_q.winner;

    qb_digit u_digit (
        .code (st_q.winner),
        .seg  (seg)
    );

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (st_q.armed == 1'b0 && st_q.winner == '0 && st_q.dq == '0));

    a_r3_toggle: assert property (@(posedge clk) disable iff (rst)
        host_rise |=> (st_q.armed != $past(st_q.armed)));

    a_r3_no_toggle: assert property (@(posedge clk) disable iff (rst)
        !host_rise |=> $stable(st_q.armed));

    a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(st_q.winner));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q.winner != '0 && !host_rise) |=> $stable(st_q.winner));

    a_r6_dq_blocks: assert property (@(posedge clk) disable iff (rst)
        (st_q.armed && st_q.winner == '0 && !host_rise)
            |=> ((st_q.winner & $past(st_q.dq)) == '0));

    a_r9_close_clears: assert property (@(posedge clk) disable iff (rst)
        (st_q.armed && host_rise) |=> (st_q.winner == '0 && st_q.dq == '0));

    a_r11_idle_no_win: assert property (@(posedge clk) disable iff (rst)
        (!st_q.armed) |=> (st_q.winner == '0));
endmodule

// File: tb/sim_quiz_lockout.sv
module sim_quiz_lockout;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_btn = 1'b0;
    logic [3:0] player_btn = '0;
    logic       armed, locked;
    logic [3:0] winner;
    logic [6:0] seg;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quiz_lockout #(.SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .host_btn(host_btn), .player_btn(player_btn),
        .armed(armed), .locked(locked), .winner(winner), .seg(seg)
    );

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_press();
        host_btn = 1'b1;
        wait_n(SETTLE);
        host_btn = 1'b0;
        wait_n(SETTLE);
    endtask

    task automatic tap(input logic [3:0] v);
        player_btn = v;
        wait_n(SETTLE);
        player_btn = '0;
        wait_n(SETTLE);
    endtask

    task automatic check_win(input string req, input logic [3:0] w, input logic [6:0] s);
        chk(req, {3'b0, winner}, {3'b0, w});
        chk(req, {6'b0, locked}, {6'b0, (w != 0)});
        chk(req, seg, s);
    endtask

    task automatic t_reset();
        chk("R1 armed", {6'b0, armed}, 7'd0);
        chk("R1 locked", {6'b0, locked}, 7'd0);
        chk("R1 winner", {3'b0, winner}, 7'd0);
        chk("R1 seg", seg, 7'd0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        host_btn = 1'b1;
        wait_n(2);
        chk("R2 not yet at edge 2", {6'b0, armed}, 7'd0);
        wait_n(1);
        chk("R2 armed at edge 3", {6'b0, armed}, 7'd1);
        wait_n(6);
        chk("R3 held host no toggle", {6'b0, armed}, 7'd1);
        host_btn = 1'b0;
        wait_n(SETTLE);
        chk("R3 release no toggle", {6'b0, armed}, 7'd1);
    endtask

    task automatic t_basic();
        tap(4'b0100);
        check_win("R4 R10 contestant 3", 4'b0100, 7'b1001111);
        tap(4'b0001);
        check_win("R5 later press ignored", 4'b0100, 7'b1001111);
        host_press();
        chk("R9 closed", {6'b0, armed}, 7'd0);
        check_win("R9 cleared", 4'b0000, 7'd0);
    endtask

    task automatic t_idle_and_early();
        tap(4'b0010);
        check_win("R11 no win while closed", 4'b0000, 7'd0);
        host_press();
        tap(4'b0010);
        check_win("R6 disqualified cannot win", 4'b0000, 7'd0);
        tap(4'b1000);
        check_win("R6 R10 other still wins", 4'b1000, 7'b1100110);
        host_press();
    endtask

    task automatic t_held();
        player_btn = 4'b0001;
        host_press();
        player_btn = '0;
        wait_n(SETTLE);
        chk("R7 armed", {6'b0, armed}, 7'd1);
        check_win("R7 held press no win", 4'b0000, 7'd0);
        tap(4'b0001);
        check_win("R7 held counts early", 4'b0000, 7'd0);
        tap(4'b0010);
        check_win("R7 R10 contestant 2", 4'b0010, 7'b1011011);
        host_press();
    endtask

    task automatic t_simul();
        host_press();
        tap(4'b1001);
        check_win("R8 R10 lowest of 1001", 4'b0001, 7'b0000110);
        host_press();
        host_press();
        tap(4'b1100);
        check_win("R8 lowest of 1100", 4'b0100, 7'b1001111);
        host_press();
        check_win("R9 final clear", 4'b0000, 7'd0);
    endtask

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(1);
        t_reset();
        t_latency();
        t_basic();
        t_idle_and_early();
        t_held();
        t_simul();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule